// File: doc/BRIEF.md
# Reloading Countdown Timer with Prioritized Interrupt Status

This block is a periodic timer with an interrupt status register. A host writes a
preset count, one byte at a time, and sets an enable bit. The counter then steps
down once every fixed number of core clocks. When it runs out it flags an
interrupt and reloads the preset, so it keeps producing interrupts at a fixed
period without any further host action. At a 12.5 MHz core clock and the default
prescale of four, the full 24-bit preset gives about 5.4 s between interrupts.

The timer is one of several interrupt sources. The other sources arrive as
request lines, and the block latches each of them on its rising edge. A single
status register shows the binary code of the pending source that has the highest
priority, where a lower code means a higher priority. The active-low interrupt
output is asserted while that register holds a code. The host acknowledges an
interrupt by writing all ones to the register. If another source is still
pending at that point, its code is loaded on the same clock edge and the
interrupt output stays asserted.

Top module: `cdtimer_irq`

## Requirements
- R1: After reset the three preset bytes and the control register read 00h, the status register reads FFh and `irq_n` is high.
- R2: The register map is: preset byte low, middle and high at addresses 0, 1 and 2, control at 3 (bit 0 is the enable), status at 4, live count low, middle and high at 5, 6 and 7. Preset bytes and control read back what was written.
- R3: While the enable is clear, the live count equals the preset and follows each preset write on the next edge. On the edge that sets the enable, the count holds the preset.
- R4: While enabled, the count changes only once every PRESCALE (4) clocks. The first change comes 4 clocks after the edge that set the enable.
- R5: Suppose a prescaled step finds the count at 1 or 0. The count reloads the preset on that edge and the timer source becomes pending, so interrupts repeat every max(preset,1) x 4 clocks with no host action.
- R6: The status register holds FFh when nothing is pending. Otherwise it holds the code of the highest-priority pending source: request line i has code i, and the timer has code N_EXT (7). `irq_n` is low exactly when the status is not FFh.
- R7: Writing FFh to the status register clears the pending flag of the source whose code is shown. With nothing else pending, the status returns to FFh and `irq_n` goes high.
- R8: Any status write other than FFh has no effect.
- R9: On the edge of an FFh write, the code of the next pending source is loaded, and `irq_n` stays low without a gap.
- R10: A displayed code is not replaced when a higher-priority source becomes pending. The newer source is shown only after the current one is cleared.
- R11: A request line sets its pending flag only on a rising edge. A line held high after being cleared does not raise a new interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| src_req | input | N_EXT | Request lines of the other interrupt sources |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The timer is run with a small preset, a zero preset and the full 24-bit preset. These runs separate the step position, the reload boundary, and borrows across the byte registers; the second interrupt of a run confirms the automatic reload period. For the status register, two requests arrive together, which tests priority encoding and the same-edge reload after an acknowledge. A higher-priority request also arrives while a lower code is shown, which separates latch-until-cleared behaviour from preemption. Non-FFh writes and request lines held high after an acknowledge confirm that neither raises or changes an interrupt.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int          BYTE_W  = 8;
    localparam logic [7:0]  NO_CODE = 8'hFF;
    localparam int          MAX_SRC = 32;

    typedef enum logic [2:0] {
        A_PRE_LO = 3'd0,
        A_PRE_MD = 3'd1,
        A_PRE_HI = 3'd2,
        A_CTRL   = 3'd3,
        A_ISTAT  = 3'd4,
        A_CNT_LO = 3'd5,
        A_CNT_MD = 3'd6,
        A_CNT_HI = 3'd7
    } reg_addr_e;

    // Lowest set index wins; FFh when the vector is empty.
    function automatic logic [7:0] prio_code(input logic [MAX_SRC-1:0] vec, input int n);
        logic [7:0] code;
        code = NO_CODE;
        for (int i = MAX_SRC - 1; i >= 0; i--) begin
            if (i < n && vec[i]) code = 8'(i);
        end
        return code;
    endfunction

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run)       phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign tick = run && (phase == LAST);
endmodule

// File: rtl/cdt_reload_cnt.sv
module cdt_reload_cnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         expire
);
    logic at_end;
    assign at_end = (count <= W'(1));
    assign expire = run && tick && at_end;

    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (!run)    count <= preset;
        else if (tick)    count <= at_end ? preset : count - 1'b1;
    end
endmodule

// File: rtl/cdt_irq_stat.sv
module cdt_irq_stat
    import cdt_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_evt,
    input  logic            ack,
    output logic [7:0]      code,
    output logic            irq_n
);
    logic [NSRC-1:0] pend, pend_nx, clr;

    always_comb begin
        clr = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (ack && code == 8'(i)) clr[i] = 1'b1;
        end
        pend_nx = (pend & ~clr) | src_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            code <= NO_CODE;
        end else begin
            pend <= pend_nx;
            if (ack || code == NO_CODE)
                code <= prio_code(MAX_SRC'(pend_nx), NSRC);
        end
    end

    assign irq_n = (code == NO_CODE);
endmodule

// File: rtl/cdtimer_irq.sv
module cdtimer_irq
    import cdt_pkg::*;
#(
    parameter int N_EXT    = 7,
    parameter int CNT_W    = 24,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [N_EXT-1:0] src_req,
    output logic             irq_n
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int NSRC   = N_EXT + 1;

    logic [CNT_W-1:0] preset_q, count;
    logic             en_q, tick, timer_evt, clr_wr;
    logic [N_EXT-1:0] src_q, src_rise;
    logic [NSRC-1:0]  src_evt;
    logic [7:0]       istat;

    for (genvar b = 0; b < NBYTES; b++) begin : g_preset
        always_ff @(posedge clk) begin
            if (rst)
                preset_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && addr == 3'(A_PRE_LO) + 3'(b))
                preset_q[b*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            src_q <= '0;
        end else begin
            if (wr_en && addr == A_CTRL) en_q <= wr_data[0];
            src_q <= src_req;
        end
    end

    assign src_rise = src_req & ~src_q;
    assign src_evt  = {timer_evt, src_rise};
    assign clr_wr   = wr_en && addr == A_ISTAT && wr_data == NO_CODE;

    cdt_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk (clk), .rst (rst), .run (en_q), .tick (tick)
    );

    cdt_reload_cnt #(.W(CNT_W)) u_cnt (
        .clk (clk), .rst (rst), .run (en_q), .tick (tick),
        .preset (preset_q), .count (count), .expire (timer_evt)
    );

    cdt_irq_stat #(.NSRC(NSRC)) u_stat (
        .clk (clk), .rst (rst), .src_evt (src_evt), .ack (clr_wr),
        .code (istat), .irq_n (irq_n)
    );

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (addr == 3'(A_PRE_LO) + 3'(b)) rd_data = preset_q[b*BYTE_W +: BYTE_W];
            if (addr == 3'(A_CNT_LO) + 3'(b)) rd_data = count[b*BYTE_W +: BYTE_W];
        end
        if (addr == A_CTRL)  rd_data = {7'd0, en_q};
        if (addr == A_ISTAT) rd_data = istat;
    end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
    parameter int NSRC  = 8,
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             en_q,
    input logic [CNT_W-1:0] preset_q,
    input logic [CNT_W-1:0] count,
    input logic             timer_evt,
    input logic [7:0]       istat,
    input logic             clr_wr
);
    // R3: a stopped counter mirrors the preset
    p_hold_preset_r3: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> count == $past(preset_q));

    // R4: a running counter moves by one step or reloads
    p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        (en_q && $past(en_q) && count != $past(count))
            |-> (count + 1'b1 == $past(count)) || $past(timer_evt));

    // R5: expiry reloads the preset and raises a code
    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
        timer_evt |=> (count == $past(preset_q)) && (istat != 8'hFF));

    // R6: a shown code always names an existing source
    p_code_range_r6: assert property (@(posedge clk) disable iff (rst)
        istat != 8'hFF |-> istat < 8'(NSRC));

    // R10: a shown code holds until an all-ones write
    p_hold_code_r10: assert property (@(posedge clk) disable iff (rst)
        (istat != 8'hFF && !clr_wr) |=> $stable(istat));
endmodule

bind cdtimer_irq cdt_checker #(.NSRC(N_EXT + 1), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_q      (en_q),
    .preset_q  (preset_q),
    .count     (count),
    .timer_evt (timer_evt),
    .istat     (istat),
    .clr_wr    (clr_wr)
);

// File: tb/cdtimer_irq_tb.sv
`timescale 1ns/1ps
module cdtimer_irq_tb_top;
    localparam int N_EXT = 7;
    localparam logic [7:0] TCODE = 8'd7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic [N_EXT-1:0] src_req = '0;
    logic irq_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        logic [7:0] d;
        logic       irq;
        string      tag;
    } exp_t;
    exp_t sb[$];

    cdtimer_irq #(.N_EXT(N_EXT)) dut_i (
        .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr),
        .wr_data (wr_data), .rd_data (rd_data), .src_req (src_req), .irq_n (irq_n)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare queued expectations against the ports
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            #2;
            it = sb.pop_front();
            n_chk++;
            if (rd_data !== it.d || irq_n !== it.irq) begin
                n_fail++;
                $display("FAIL %s: rd_data=%02h irq_n=%0b expected rd_data=%02h irq_n=%0b",
                         it.tag, rd_data, irq_n, it.d, it.irq);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // driver: point the read port and push the expectation
    task automatic chk(input logic [2:0] a, input logic [7:0] d, input logic irq, input string tag);
        exp_t it;
        addr = a;
        it.d = d; it.irq = irq; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic cmp(input int act, input int expv, input string tag);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t1;
        int t2;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk(3'd0, 8'h00, 1'b1, "R1 preset lo");
        chk(3'd2, 8'h00, 1'b1, "R1 preset hi");
        chk(3'd3, 8'h00, 1'b1, "R1 ctrl");
        chk(3'd4, 8'hFF, 1'b1, "R1 status");

        // R2 / R3 readback and stopped counter
        wr(3'd0, 8'h12);
        wr(3'd1, 8'h34);
        wr(3'd2, 8'h56);
        chk(3'd1, 8'h34, 1'b1, "R2 preset md");
        chk(3'd5, 8'h12, 1'b1, "R3 count lo follows preset");
        chk(3'd7, 8'h56, 1'b1, "R3 count hi follows preset");
        tick(10);
        chk(3'd6, 8'h34, 1'b1, "R3 count stays at preset");

        // R4 / R5 timer with preset 3
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);
        tick(1);
        wr(3'd3, 8'h01);                       // enable edge E0
        chk(3'd5, 8'h03, 1'b1, "R3 preset loaded on enable");
        tick(3);                               // E3
        chk(3'd5, 8'h03, 1'b1, "R4 no step before 4 clocks");
        tick(1);                               // E4
        chk(3'd5, 8'h02, 1'b1, "R4 first step");
        tick(4);                               // E8
        chk(3'd5, 8'h01, 1'b1, "R4 second step");
        tick(3);                               // E11
        chk(3'd5, 8'h01, 1'b1, "R5 not yet expired");
        tick(1);                               // E12
        t1 = cyc;
        chk(3'd5, 8'h03, 1'b0, "R5 reload and interrupt");
        chk(3'd4, TCODE, 1'b0, "R6 timer code");
        chk(3'd3, 8'h01, 1'b0, "R2 ctrl readback");
        wr(3'd4, 8'h00);
        chk(3'd4, TCODE, 1'b0, "R8 non-FF write ignored");
        wr(3'd4, 8'hFF);
        chk(3'd4, 8'hFF, 1'b1, "R7 clear releases irq");
        t2 = t1;
        for (int k = 0; k < 40; k++) begin
            if (irq_n == 1'b0) break;
            tick(1);
            t2 = cyc;
        end
        cmp(t2 - t1, 12, "R5 automatic reload period");
        wr(3'd3, 8'h00);
        wr(3'd4, 8'hFF);
        chk(3'd4, 8'hFF, 1'b1, "R7 cleared after disable");

        // R5 zero preset: expires every 4 clocks
        wr(3'd0, 8'h00);
        tick(1);
        wr(3'd3, 8'h01);                       // E0
        tick(3);
        chk(3'd4, 8'hFF, 1'b1, "R5 zero preset before step");
        tick(1);
        chk(3'd4, TCODE, 1'b0, "R5 zero preset expires at first step");
        wr(3'd3, 8'h00);
        wr(3'd4, 8'hFF);

        // R4 full 24-bit preset borrows across bytes
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'hFF);
        tick(1);
        wr(3'd3, 8'h01);                       // E0
        tick(4);
        chk(3'd5, 8'hFE, 1'b1, "R4 full count low byte");
        chk(3'd7, 8'hFF, 1'b1, "R4 full count high byte");
        wr(3'd3, 8'h00);
        chk(3'd4, 8'hFF, 1'b1, "R8 no interrupt from full count");

        // R6 / R9 two requests together
        src_req = 7'b0000101;
        tick(2);
        chk(3'd4, 8'h00, 1'b0, "R6 highest priority shown");
        wr(3'd4, 8'hFF);
        chk(3'd4, 8'h02, 1'b0, "R9 next code loaded at once");
        wr(3'd4, 8'h55);
        chk(3'd4, 8'h02, 1'b0, "R8 other write ignored");
        wr(3'd4, 8'hFF);
        chk(3'd4, 8'hFF, 1'b1, "R7 all cleared");
        tick(3);
        chk(3'd4, 8'hFF, 1'b1, "R11 held level does not re-raise");
        src_req = '0;
        tick(2);

        // R10 no preemption
        src_req = 7'b0001000;
        tick(2);
        chk(3'd4, 8'h03, 1'b0, "R6 code 3 shown");
        src_req = 7'b0001010;
        tick(3);
        chk(3'd4, 8'h03, 1'b0, "R10 not preempted");
        wr(3'd4, 8'hFF);
        chk(3'd4, 8'h01, 1'b0, "R10 higher source after clear");
        wr(3'd4, 8'hFF);
        chk(3'd4, 8'hFF, 1'b1, "R7 final clear");
        src_req = '0;
        tick(2);
        src_req = 7'b1000000;
        tick(2);
        chk(3'd4, 8'h06, 1'b0, "R11 new rising edge raises code 6");

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule